// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that sits in ordinary memory. When a request is accepted, it reads one 4-byte entry from the top-level table, which the root base input locates. That entry names the page that holds a second-level table. It then reads one 4-byte entry from that second-level table, which gives the physical page frame. The frame is joined with the untranslated 12-bit page offset, and the result comes back on a one-cycle response, or a fault is reported if an entry along the way is not marked valid.

The virtual address splits into a 10-bit top index (bits 31:22), a 10-bit second index (bits 21:12) and a 12-bit page offset (bits 11:0). Each table therefore has 1024 entries and fills exactly one 4 KB page. In every entry, bit 0 is the valid flag and bits 31:12 are a page frame number. Bits 11:1 carry no meaning for the walk. The memory side is a single-outstanding read port: a request held until it is taken, followed later by exactly one data return. Only one walk is in flight at a time.

Top module: `two_level_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_req_valid and rsp_valid are 0.
- R2: The first memory read of a walk is at root_base + 4 * vaddr[31:22].
- R3: The second memory read is at (bits 31:12 of the first entry) * 4096 + 4 * vaddr[21:12].
- R4: When both entries have bit 0 set, the response has rsp_fault = 0 and rsp_paddr = {second entry bits 31:12, vaddr[11:0]}.
- R5: A first entry with bit 0 clear ends the walk after exactly one memory read, with rsp_fault = 1, rsp_fault_level = 0 and rsp_paddr = 0.
- R6: A second entry with bit 0 clear ends the walk after exactly two memory reads, with rsp_fault = 1, rsp_fault_level = 1 and rsp_paddr = 0.
- R7: From the cycle a request is accepted until its response has been given, req_ready is 0 and a request held on req_valid is not taken.
- R8: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr stays unchanged on the next cycle.
- R9: Every accepted request produces exactly one response, and rsp_valid is high for a single cycle.
- R10: root_base is captured when the request is accepted; changing it during the walk does not change the result.
- R11: Entry bits 11:1 have no effect on addresses, frames or fault decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical address of the top-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory takes the read this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned table entry |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_paddr | output | 32 | Translated physical address, 0 on a fault |
| rsp_fault | output | 1 | Walk hit an entry with its valid bit clear |
| rsp_fault_level | output | 1 | 0 if the fault was in the top table, 1 if in the second table |

## Verification
A walker stuck in the wrong state shows up first on the memory port. A lost transition shows as a read at the wrong address or a missing or extra read, and that happens within one read of the mistake. It never waits until the final answer. A corrupted latch of the address or the frame shows at the second read address or in the response word of the same walk. A broken busy indication shows as a second request accepted in the middle of a walk, which brings an extra response within a few cycles. Stalls on both the read request and the data return make any handshake that does not hold its address appear on the very cycle the memory takes it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PTE_W   = 32;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int ENT_SH  = $clog2(PTE_W / 8);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_L1,
        ST_WAIT_L1,
        ST_READ_L2,
        ST_WAIT_L2,
        ST_RESP
    } walk_state_e;

    // Virtual address fields, most significant first
    typedef struct packed {
        logic [IDX_W-1:0] top_idx;
        logic [IDX_W-1:0] sub_idx;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    // Table entry layout
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFF_W-2:0]   spare;
        logic               valid;
    } pte_t;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic            fault;
        logic            level;
    } walk_result_t;

    function automatic logic [VA_W-1:0] entry_offset(input logic [IDX_W-1:0] idx);
        entry_offset = VA_W'(idx) << ENT_SH;
    endfunction

    function automatic logic [VA_W-1:0] frame_base(input logic [FRAME_W-1:0] frame);
        frame_base = {frame, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]    base,
    input  vaddr_t             va,
    input  logic [FRAME_W-1:0] sub_table,
    input  logic               second_level,
    output logic [VA_W-1:0]    entry_addr
);
    logic [VA_W-1:0] top_addr;
    logic [VA_W-1:0] sub_addr;

    assign top_addr = base + entry_offset(va.top_idx);
    assign sub_addr = frame_base(sub_table) + entry_offset(va.sub_idx);

    always_comb begin
        entry_addr = second_level ? sub_addr : top_addr;
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   raw,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    pte_t entry;

    assign entry   = pte_t'(raw);
    assign present = entry.valid;
    assign frame   = entry.frame;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [VA_W-1:0]    root_base,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               ent_present,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic               second_level,
    output logic [VA_W-1:0]    base_q,
    output vaddr_t             va_q,
    output logic [FRAME_W-1:0] sub_table_q,
    output logic               rsp_valid,
    output walk_result_t       result_q
);
    walk_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid)     state_nx = ST_READ_L1;
            ST_READ_L1: if (mem_req_ready) state_nx = ST_WAIT_L1;
            ST_WAIT_L1: if (mem_rsp_valid) state_nx = ent_present ? ST_READ_L2 : ST_RESP;
            ST_READ_L2: if (mem_req_ready) state_nx = ST_WAIT_L2;
            ST_WAIT_L2: if (mem_rsp_valid) state_nx = ST_RESP;
            ST_RESP:                       state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            base_q      <= '0;
            va_q        <= '0;
            sub_table_q <= '0;
            result_q    <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q   <= root_base;
                        va_q     <= vaddr_t'(req_vaddr);
                        result_q <= '0;
                    end
                end
                ST_WAIT_L1: begin
                    if (mem_rsp_valid) begin
                        sub_table_q <= ent_frame;
                        if (!ent_present) begin
                            result_q.fault <= 1'b1;
                            result_q.level <= 1'b0;
                            result_q.paddr <= '0;
                        end
                    end
                end
                ST_WAIT_L2: begin
                    if (mem_rsp_valid) begin
                        if (ent_present) begin
                            result_q.fault <= 1'b0;
                            result_q.paddr <= {ent_frame, va_q.off};
                        end else begin
                            result_q.fault <= 1'b1;
                            result_q.level <= 1'b1;
                            result_q.paddr <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_READ_L1) || (state == ST_READ_L2);
    assign second_level  = (state == ST_READ_L2);
    assign rsp_valid     = (state == ST_RESP);
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] root_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            rsp_fault_level
);
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic               second_level;
    logic [VA_W-1:0]    base_q;
    vaddr_t             va_q;
    logic [FRAME_W-1:0] sub_table_q;
    walk_result_t       result_q;

    ptw_pte_decode u_decode (
        .raw     (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .root_base     (root_base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (ent_present),
        .ent_frame     (ent_frame),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .second_level  (second_level),
        .base_q        (base_q),
        .va_q          (va_q),
        .sub_table_q   (sub_table_q),
        .rsp_valid     (rsp_valid),
        .result_q      (result_q)
    );

    ptw_addr_gen u_addr (
        .base         (base_q),
        .va           (va_q),
        .sub_table    (sub_table_q),
        .second_level (second_level),
        .entry_addr   (mem_req_addr)
    );

    assign rsp_paddr       = result_q.paddr;
    assign rsp_fault       = result_q.fault;
    assign rsp_fault_level = result_q.level;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [VA_W-1:0]  root_base,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [VA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [PTE_W-1:0] mem_rsp_data,
    input logic             rsp_valid,
    input logic [VA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             rsp_fault_level
);
    // Independent record of the walk seen at the ports
    logic [1:0]      reads_seen;
    logic [VA_W-1:0] chk_base;
    vaddr_t          chk_va;
    logic [PTE_W-1:0] chk_top_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            reads_seen  <= '0;
            chk_base    <= '0;
            chk_va      <= '0;
            chk_top_ent <= '0;
        end else begin
            if (req_valid && req_ready) begin
                reads_seen <= '0;
                chk_base   <= root_base;
                chk_va     <= vaddr_t'(req_vaddr);
            end else if (mem_req_valid && mem_req_ready) begin
                reads_seen <= reads_seen + 2'd1;
            end
            if (mem_rsp_valid && reads_seen == 2'd1) chk_top_ent <= mem_rsp_data;
        end
    end

    a_r2_top_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && reads_seen == 2'd0)
        |-> mem_req_addr == chk_base + (VA_W'(chk_va.top_idx) << ENT_SH));

    a_r3_sub_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && reads_seen == 2'd1)
        |-> mem_req_addr == ({chk_top_ent[PTE_W-1:OFF_W], {OFF_W{1'b0}}}
                             + (VA_W'(chk_va.sub_idx) << ENT_SH)));

    a_r5_top_fault_reads: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault && !rsp_fault_level) |-> reads_seen == 2'd1);

    a_r6_sub_fault_reads: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault && rsp_fault_level) |-> reads_seen == 2'd2);

    a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> rsp_paddr == '0);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_rsp_while_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r8_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind two_level_walker ptw_checker u_ptw_checker (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .root_base       (root_base),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_fault       (rsp_fault),
    .rsp_fault_level (rsp_fault_level)
);

// File: tb/two_level_walker_bench.sv
module two_level_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_level;

    always #2 clk = ~clk;

    two_level_walker u_two_level_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
    );

    int checks = 0;
    int errors = 0;
    int n_rsp  = 0;

    logic [31:0] image [logic [31:0]];
    logic [31:0] exp_addr_q [$];
    logic [33:0] exp_rsp_q  [$];   // {paddr, fault, level}

    function automatic logic [31:0] rd(input logic [31:0] a);
        rd = image.exists(a) ? image[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mkva(input int hi, input int lo, input int off);
        mkva = {hi[9:0], lo[9:0], off[11:0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model and monitor, all at the falling edge
    int          pat = 0;
    logic        pend = 1'b0;
    int          pend_dly = 0;
    logic [31:0] pend_addr = '0;

    always @(negedge clk) begin
        pat++;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_dly == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(pend_addr);
                pend = 1'b0;
            end else pend_dly--;
        end
        mem_req_ready <= (pat % 3) != 0;
        if (!rst && mem_req_valid && ((pat % 3) != 0)) begin
            pend      = 1'b1;
            pend_dly  = pat % 4;
            pend_addr = mem_req_addr;
            if (exp_addr_q.size() == 0)
                check("R5/R6 extra memory read", {32'h0, mem_req_addr}, 64'hDEAD);
            else
                check("R2/R3 read address", {32'h0, mem_req_addr}, {32'h0, exp_addr_q.pop_front()});
        end
        if (!rst && rsp_valid) begin
            n_rsp++;
            if (exp_rsp_q.size() == 0)
                check("R9 unexpected response", {30'h0, rsp_paddr, rsp_fault, rsp_fault_level}, 64'hDEAD);
            else
                check("R4/R5/R6 response", {30'h0, rsp_paddr, rsp_fault, rsp_fault_level},
                      {30'h0, exp_rsp_q.pop_front()});
        end
    end

    // Driver: computes the expected walk from the requirements and issues it
    task automatic walk(input logic [31:0] va, input logic [31:0] base);
        logic [31:0] a1, e1, a2, e2;
        int target;
        a1 = base + {20'h0, va[31:22], 2'b00};
        e1 = rd(a1);
        exp_addr_q.push_back(a1);
        if (!e1[0]) exp_rsp_q.push_back({32'h0, 1'b1, 1'b0});
        else begin
            a2 = {e1[31:12], va[21:12], 2'b00};
            e2 = rd(a2);
            exp_addr_q.push_back(a2);
            if (!e2[0]) exp_rsp_q.push_back({32'h0, 1'b1, 1'b1});
            else        exp_rsp_q.push_back({e2[31:12], va[11:0], 1'b0, 1'b0});
        end
        target = n_rsp + 1;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; root_base = base;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        // R7 and R10: hold a second request and disturb the base mid-walk
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            req_vaddr = ~va; root_base = base ^ 32'h0055_5000;
            check("R7 busy during walk", {63'h0, req_ready}, 64'h0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (n_rsp < target) @(negedge clk);
    endtask

    task automatic run_all();
        // Tables: base A at 0x0010_0000, base B at 0x0040_0000
        image[32'h0010_0004] = 32'h0020_0001;              // top idx 1 -> sub table 0x00200
        image[32'h0020_0000 + 4*5]   = 32'h0ABC_DFFF;      // R11: spare bits all set
        image[32'h0020_0000 + 4*0]   = 32'h0000_0001;      // frame 0
        image[32'h0020_0000 + 4*9]   = 32'h1234_5000;      // sub invalid
        image[32'h0010_0000 + 4*1023] = 32'h0030_0FFE;     // top invalid, spare bits set
        image[32'h0010_0000 + 4*0]   = 32'h0050_0001;      // top idx 0 -> 0x00500
        image[32'h0050_0000 + 4*1023] = 32'hFFFF_F001;     // frame all ones
        image[32'h0040_0004] = 32'h0060_0FFF;              // base B idx 1 -> 0x00600
        image[32'h0060_0000 + 4*5]   = 32'h0777_7001;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset req_ready", {63'h0, req_ready}, 64'h1);
        check("R1 reset mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
        check("R1 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);

        walk(mkva(1, 5, 12'h123), 32'h0010_0000);    // R4 R11
        walk(mkva(1, 0, 0), 32'h0010_0000);          // R4 frame 0
        walk(mkva(1, 9, 12'hABC), 32'h0010_0000);    // R6
        walk(mkva(1023, 0, 12'h7), 32'h0010_0000);   // R5
        walk(32'hFFFF_FFFF, 32'h0010_0000);          // R5 all-ones address
        walk(mkva(0, 1023, 12'hFFF), 32'h0010_0000); // R4 top corner
        walk(mkva(2, 3, 4), 32'h0010_0000);          // R5 absent entry
        walk(mkva(1, 5, 12'h456), 32'h0040_0000);    // R10 other base
        walk(mkva(1, 5, 12'h0), 32'h0010_0000);      // R10 back to first base

        repeat (10) @(negedge clk);
        check("R9 responses outstanding", 64'(exp_rsp_q.size()), 64'h0);
        check("R5/R6 reads outstanding", 64'(exp_addr_q.size()), 64'h0);
        check("R9 response count", 64'(n_rsp), 64'd9);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL R9 watchdog responses %0d expected 9", n_rsp);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule